// File: doc/BRIEF.md
# Sliding Window Line Buffer

The block takes a raster stream of pixels and replays a square neighbourhood around each window position, one pixel per clock. Pixels arrive over a valid/ready handshake, together with a commit strobe that decides which of the accepted pixels may be used for windows. Accepted pixels go into a small circular store. A sequencer walks the window base through linear pixel indices 0, 1, 2, ... and reads each window back in row-major order. The output is a data word with a valid flag. The output has no back-pressure, so the consumer must take every valid word in the cycle it appears.

Back-pressure exists on the input side only. The producer keeps its pixel and raises `px_valid`, and the transfer happens on the clock edge where `px_ready` is also high. `px_ready` drops for one of two reasons: the next write would overwrite a slot that a pending window still needs, or the whole frame has already been accepted. A frame is `IMG_W*IMG_W` pixels. It ends after the last window has been emitted and the last pixel has been accepted. At that point the block rearms itself for the next frame.

With the defaults (8-pixel rows, a 3x3 kernel, 8-bit pixels), the window needs a span of 19 consecutive pixels and the store holds 32.

Top module: `line_window_buf`

## Requirements
- R1: A pixel is transferred only on a rising edge where `px_valid` and `px_ready` are both high. Pixels are numbered 0, 1, 2, ... in transfer order. `px_data` has no effect in cycles without a transfer.
- R2: `px_commit` high in a cycle makes every pixel transferred up to and including that cycle usable for windows, whether or not `px_valid` is high. Pixels transferred while `px_commit` is low are not usable until a later cycle with `px_commit` high.
- R3: Each window is 9 words (KSIZE squared). Word number y*KSIZE+x carries pixel index base + y*IMG_W + x, so the words come in row-major order (x fastest).
- R4: Once a window starts, its words appear on `win_valid`/`win_data` in consecutive cycles. Each word appears one cycle after the window position is issued. `win_valid` never waits on the consumer.
- R5: The window base is 0 for the first window of a frame and rises by exactly 1 per window, up to (IMG_W-KSIZE+1)^2-1 = 35. A frame therefore yields 324 valid words.
- R6: A window with base b starts only in a cycle where at least b+19 pixels, that is (KSIZE-1)*IMG_W+KSIZE, are already usable. Until then `win_valid` stays low.
- R7: `px_ready` is low exactly when the frame count has reached IMG_W*IMG_W transfers, or when the transfer count is at least the current base plus 32 (the store depth, the smallest power of two not below the span).
- R8: Synchronous active-high `rst` clears all counts and the window position. In the cycle after reset, `win_valid` is low and `px_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| px_valid | input | 1 | Producer holds a pixel |
| px_ready | output | 1 | Block can take a pixel this cycle |
| px_data | input | PIX_W | Pixel value |
| px_commit | input | 1 | Make all transferred pixels usable |
| win_data | output | PIX_W | Current window pixel |
| win_valid | output | 1 | `win_data` holds a window pixel |

## Verification
The bench compares `win_data` against the pixel it expects at every position. A wrong write pointer or a wrong read offset inside the store therefore shows up on the very first word of a window that reads the corrupted slot. A wrong usable count or a wrong window base moves the start of a window by at least one cycle, and `win_valid` disagrees with the model on that cycle. Overwrite protection is checked through `px_ready`, which the bench compares on every cycle. A missed stall shows up as a mismatch on the same cycle, and its corrupted data reaches `win_data` a few windows later.

// File: rtl/lwb_pkg.sv
package lwb_pkg;
  typedef enum logic [1:0] {
    SQ_WAIT = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/lwb_store.sv
module lwb_store #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [PIX_W-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [PIX_W-1:0] rdata,
  output logic             rvalid
);
  logic [PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= re;
  end
endmodule

// File: rtl/lwb_wr_ctrl.sv
module lwb_wr_ctrl #(
  parameter int TOTAL = 64,
  parameter int DEPTH = 32,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          px_valid,
  input  logic          px_commit,
  input  logic [CW-1:0] base,
  input  logic          restart,
  output logic          px_ready,
  output logic          accept,
  output logic [CW-1:0] wr_ptr,
  output logic [CW-1:0] cm_ptr
);
  logic room;
  logic not_full;

  assign not_full = wr_ptr < CW'(TOTAL);
  assign room     = wr_ptr < (base + CW'(DEPTH));
  assign px_ready = !restart && not_full && room;
  assign accept   = px_valid && px_ready;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      wr_ptr <= '0;
      cm_ptr <= '0;
    end else begin
      if (accept)    wr_ptr <= wr_ptr + CW'(1);
      if (px_commit) cm_ptr <= wr_ptr + CW'(accept);
    end
  end

  // R2: the usable count never runs ahead of the transfer count
  a_r2_commit_bound: assert property (@(posedge clk) disable iff (rst)
    cm_ptr <= wr_ptr);

  // R1: without a transfer the write pointer holds
  a_r1_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    (!accept && !restart) |=> wr_ptr == $past(wr_ptr));
endmodule

// File: rtl/lwb_rd_seq.sv
module lwb_rd_seq
  import lwb_pkg::*;
#(
  parameter int IMG_W = 8,
  parameter int KSIZE = 3,
  parameter int NWIN  = 36,
  parameter int SPAN  = 19,
  parameter int CW    = 7,
  parameter int KW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cm_ptr,
  input  logic          wr_full,
  output logic          issue,
  output logic [CW-1:0] rd_idx,
  output logic [CW-1:0] base,
  output logic          restart
);
  seq_state_e state;
  logic [KW-1:0] kx, ky;
  logic gate, last_px;

  assign gate    = cm_ptr >= (base + CW'(SPAN));
  assign issue   = (state == SQ_RUN) || ((state == SQ_WAIT) && gate);
  assign restart = (state == SQ_DONE) && wr_full;
  assign last_px = (kx == KW'(KSIZE - 1)) && (ky == KW'(KSIZE - 1));
  assign rd_idx  = base + CW'(ky) * CW'(IMG_W) + CW'(kx);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      state <= SQ_WAIT;
      base  <= '0;
      kx    <= '0;
      ky    <= '0;
    end else if (issue) begin
      if (last_px) begin
        kx    <= '0;
        ky    <= '0;
        base  <= base + CW'(1);
        state <= (base == CW'(NWIN - 1)) ? SQ_DONE : SQ_WAIT;
      end else begin
        state <= SQ_RUN;
        if (kx == KW'(KSIZE - 1)) begin
          kx <= '0;
          ky <= ky + KW'(1);
        end else begin
          kx <= kx + KW'(1);
        end
      end
    end
  end

  // R5: the base never passes the window count
  a_r5_base_bound: assert property (@(posedge clk) disable iff (rst)
    base <= CW'(NWIN));

  // R4: a window that has started continues without a gap
  a_r4_run_next: assert property (@(posedge clk) disable iff (rst)
    (issue && !last_px) |=> issue);
endmodule

// File: rtl/line_window_buf.sv
module line_window_buf #(
  parameter int IMG_W = 8,
  parameter int KSIZE = 3,
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             px_valid,
  output logic             px_ready,
  input  logic [PIX_W-1:0] px_data,
  input  logic             px_commit,
  output logic [PIX_W-1:0] win_data,
  output logic             win_valid
);
  localparam int TOTAL = IMG_W * IMG_W;
  localparam int NWIN  = (IMG_W - KSIZE + 1) * (IMG_W - KSIZE + 1);
  localparam int SPAN  = (KSIZE - 1) * IMG_W + KSIZE;
  localparam int AW    = $clog2(SPAN);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(TOTAL + DEPTH + 1);
  localparam int KW    = (KSIZE > 1) ? $clog2(KSIZE) : 1;

  logic          accept, restart, issue;
  logic [CW-1:0] wr_ptr, cm_ptr, base, rd_idx;

  lwb_wr_ctrl #(.TOTAL(TOTAL), .DEPTH(DEPTH), .CW(CW)) u_wr (
    .clk, .rst, .px_valid, .px_commit, .base, .restart,
    .px_ready, .accept, .wr_ptr, .cm_ptr
  );

  lwb_rd_seq #(.IMG_W(IMG_W), .KSIZE(KSIZE), .NWIN(NWIN), .SPAN(SPAN),
               .CW(CW), .KW(KW)) u_seq (
    .clk, .rst, .cm_ptr, .wr_full(wr_ptr == CW'(TOTAL)),
    .issue, .rd_idx, .base, .restart
  );

  lwb_store #(.PIX_W(PIX_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk, .rst, .we(accept), .waddr(wr_ptr[AW-1:0]), .wdata(px_data),
    .re(issue), .raddr(rd_idx[AW-1:0]), .rdata(win_data), .rvalid(win_valid)
  );

  // R7: a transfer never lands on a slot still owned by the current window
  a_r7_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    accept |-> (wr_ptr - base) < CW'(DEPTH));

  // R6: every pixel read for a window is already usable
  a_r6_data_committed: assert property (@(posedge clk) disable iff (rst)
    issue |-> rd_idx < cm_ptr);

  // R8: reset silences the output on the next cycle
  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |=> !win_valid);
endmodule

// File: tb/line_window_buf_test.sv
module line_window_buf_test;
  localparam int W = 8, K = 3, PW = 8;
  localparam int TOTAL = W * W;
  localparam int SPAN = (K - 1) * W + K;
  localparam int DEPTH = 32;
  localparam int NWIN = (W - K + 1) * (W - K + 1);
  localparam int WORDS = NWIN * K * K;

  logic clk = 1'b0, rst = 1'b1;
  logic px_valid = 1'b0, px_commit = 1'b0;
  logic [PW-1:0] px_data = '0;
  logic px_ready, win_valid;
  logic [PW-1:0] win_data;

  always #2 clk = ~clk;

  line_window_buf #(.IMG_W(W), .KSIZE(K), .PIX_W(PW)) uut (
    .clk, .rst, .px_valid, .px_ready, .px_data, .px_commit, .win_data, .win_valid
  );

  int checks = 0, failures = 0, cyc = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_wr = 0, m_cm = 0, m_base = 0, m_kx = 0, m_ky = 0, m_state = 0;
  int pix [TOTAL];
  bit exp_valid = 0, m_ready = 1, m_stalled = 0;
  int exp_data = 0, m_frames = 0, dut_words = 0, dut_accepts = 0;

  always @(posedge clk) begin
    bit acc, iss, rs, rdy;
    if (rst) begin
      m_wr = 0; m_cm = 0; m_base = 0; m_kx = 0; m_ky = 0; m_state = 0;
      exp_valid = 0;
    end else begin
      rdy = (m_wr < TOTAL) && (m_wr < m_base + DEPTH);
      acc = px_valid && rdy;
      iss = (m_state == 1) || (m_state == 0 && m_cm >= m_base + SPAN);
      rs  = (m_state == 2) && (m_wr == TOTAL);
      exp_valid = iss;
      if (iss) exp_data = pix[m_base + m_ky * W + m_kx];
      if (acc) pix[m_wr] = int'(px_data);
      if (px_commit) m_cm = m_wr + (acc ? 1 : 0);
      if (acc) m_wr++;
      if (iss) begin
        if (m_kx == K - 1 && m_ky == K - 1) begin
          m_kx = 0; m_ky = 0; m_base++;
          m_state = (m_base == NWIN) ? 2 : 0;
        end else begin
          m_state = 1;
          if (m_kx == K - 1) begin m_kx = 0; m_ky++; end else m_kx++;
        end
      end
      if (rs) begin
        m_wr = 0; m_cm = 0; m_base = 0; m_kx = 0; m_ky = 0; m_state = 0;
        m_frames++;
      end
    end
    m_ready = (m_wr < TOTAL) && (m_wr < m_base + DEPTH);
    if (!m_ready && m_wr < TOTAL) m_stalled = 1;
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(win_valid == exp_valid, "R6", "win_valid timing (R4 R5)", int'(win_valid), int'(exp_valid));
      if (exp_valid && win_valid)
        chk(int'(win_data) == exp_data, "R3", "window pixel", int'(win_data), exp_data);
      chk(px_ready == m_ready, "R7", "px_ready", int'(px_ready), int'(m_ready));
      if (win_valid) dut_words++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [PW-1:0] pval(int fr, int i);
    return PW'((i * 37 + fr * 11 + 5) % 256);
  endfunction

  // mode 0: commit every pixel; 1: gaps and sparse commits; 2: withheld commits
  task automatic push_frame(int fr, int mode, int npix);
    int i = 0, lc = 0;
    dut_accepts = 0;
    while (i < npix) begin
      @(negedge clk);
      lc++;
      if (mode == 2 && i == 25) begin
        px_valid = 1'b0; px_commit = 1'b0; px_data = 8'hEE;
        begin
          int w0 = dut_words;
          repeat (12) @(negedge clk);
          // R2: pixels 0..24 are transferred but not usable, so no window may start
          chk(dut_words == w0, "R2", "words while uncommitted", dut_words - w0, 0);
        end
        px_commit = 1'b1;
        @(negedge clk);
        px_commit = 1'b0;
        mode = 0;
        continue;
      end
      if (mode == 1 && (lc % 5) == 2) begin
        px_valid = 1'b0; px_data = 8'hEE; px_commit = ((lc % 3) == 0);
      end else begin
        px_valid = 1'b1; px_data = pval(fr, i);
        if (mode == 0) px_commit = 1'b1;
        else if (mode == 2) px_commit = 1'b0;
        else px_commit = ((i % 5) == 4) || (i == TOTAL - 1);
      end
      #1;
      if (px_valid && px_ready) begin i++; dut_accepts++; end
    end
    @(negedge clk);
    px_valid = 1'b0; px_commit = 1'b0; px_data = '0;
  endtask

  task automatic run_frame(int fr, int mode);
    int f0 = m_frames, w0 = dut_words;
    push_frame(fr, mode, TOTAL);
    chk(dut_accepts == TOTAL, "R1", "transfers per frame", dut_accepts, TOTAL);
    wait (m_frames == f0 + 1);
    @(negedge clk); @(negedge clk);
    chk(dut_words - w0 == WORDS, "R5", "words per frame", dut_words - w0, WORDS);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(win_valid == 1'b0, "R8", "win_valid in reset", int'(win_valid), 0);
    chk(px_ready == 1'b1, "R8", "px_ready in reset", int'(px_ready), 1);
    rst = 1'b0;
    run_frame(1, 0);
    chk(m_stalled == 1, "R7", "input stall observed", int'(m_stalled), 1);
    run_frame(2, 1);
    run_frame(3, 2);
    push_frame(4, 0, 30);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(win_valid == 1'b0, "R8", "win_valid after mid-run reset", int'(win_valid), 0);
    chk(px_ready == 1'b1, "R8", "px_ready after mid-run reset", int'(px_ready), 1);
    rst = 1'b0;
    run_frame(5, 0);
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule